// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a programmed mode word into burst settings (beat count, ordering and CAS latency). It then produces, one per clock, the 8-bit column addresses of a single read or write burst. A memory controller loads the mode word once, then pulses `start` with the first column of an access. The block presents one column per cycle with a valid flag and marks the final beat.

Two orderings are supported within an aligned block of the burst length. Linear ordering counts upward and wraps to the block start. Interleaved ordering XORs the start column with the beat count. A full-page setting walks all 256 columns in order and keeps going until `stop` is raised. If the access was started with auto-precharge enabled, the block raises a one-cycle precharge request once the burst has ended, whether it ran to completion or was stopped early. Data paths and command-bus driving are handled elsewhere.

Top module: `burst_col_gen`

## Requirements
- R1: The mode word is decoded as follows. Bits [2:0] select the burst length: 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, 7 gives full page, and 4 to 6 give 1 beat. Bit 3 set selects interleaved ordering. Bits [6:4] appear on `cas_lat` in the cycle after `mode_load` is sampled. Bit 7 is unused. After reset the mode word is all zeros.
- R2: In the cycle after `start` is sampled, `col_valid` is high and `col` equals `start_col`.
- R3: With linear ordering and N beats, beat b is `(start_col & ~(N-1)) | ((start_col + b) & (N-1))`.
- R4: With interleaved ordering and N beats, beat b is `(start_col & ~(N-1)) | ((start_col ^ b) & (N-1))`.
- R5: In full page mode, beat b is `(start_col + b) mod 256`. Beats continue past 256 until a stop. `col_last` is never high, and the ordering bit has no effect.
- R6: A non-full burst presents exactly N valid beats. `col_last` is high only on the final beat, and `col_valid` is low in the following cycle unless a new start was sampled.
- R7: When `stop` is sampled high while a beat is valid, that beat is the final one, and `col_valid` is low in the next cycle. `stop` has no effect while idle.
- R8: When `start_ap` was high at the start, `ap_req` is high for exactly one cycle: the cycle after the final beat, whether the burst ended normally or through a stop. When `start_ap` was low, `ap_req` stays low.
- R9: A `start` sampled during a burst restarts at the new column. The abandoned burst raises no `ap_req`. `start` wins over `stop` in the same cycle.
- R10: A burst uses the mode captured when it started. A `mode_load` during the burst changes only later bursts.
- R11: During and right after reset, `col_valid`, `col_last` and `ap_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Writes `mode_word` into the mode register |
| mode_word | input | 8 | Mode word: length [2:0], ordering [3], CAS latency [6:4] |
| start | input | 1 | Begins a burst at `start_col` |
| start_col | input | 8 | First column of the burst |
| start_ap | input | 1 | Auto-precharge enable for this burst |
| stop | input | 1 | Ends the running burst after the current beat |
| cas_lat | output | 3 | Programmed CAS latency |
| col | output | 8 | Current column address |
| col_valid | output | 1 | `col` holds a beat of the burst |
| col_last | output | 1 | Current beat is the last of a non-full burst |
| ap_req | output | 1 | One-cycle auto-precharge request |

## Verification
Each result is due a fixed number of cycles after its cause. `cas_lat` and the first beat appear one cycle after `mode_load` or `start` is sampled. Beat b of a burst is due b cycles after that, and `ap_req` follows one cycle after the final beat. The bench drives every input on the falling edge and samples outputs on the next falling edge, so each check falls exactly one rising edge after the input that caused it. The bench walks beat by beat and checks that the burst ends, stops or restarts at the expected beat.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  localparam int COL_W = 8;
  localparam int MODE_W = 8;
  localparam int CL_W = 3;
  localparam int LEN_W = 3;

  typedef struct packed {
    logic [LEN_W-1:0] len_log2;
    logic             full;
    logic             ilv;
  } burst_cfg_t;

  function automatic burst_cfg_t decode_cfg(logic [MODE_W-1:0] w);
    burst_cfg_t c;
    c.len_log2 = '0;
    c.full     = 1'b0;
    case (w[2:0])
      3'd0, 3'd1, 3'd2, 3'd3: c.len_log2 = w[2:0];
      3'd7:                   c.full = 1'b1;
      default:                c.len_log2 = '0;
    endcase
    c.ilv = w[3] & ~c.full;
    return c;
  endfunction

  function automatic logic [COL_W-1:0] len_mask(logic [LEN_W-1:0] l2);
    logic [15:0] one;
    one = 16'd1 << l2;
    return COL_W'(one - 16'd1);
  endfunction

  function automatic logic [COL_W-1:0] col_at(logic [COL_W-1:0] s,
                                              logic [COL_W-1:0] beat,
                                              burst_cfg_t c);
    logic [COL_W-1:0] m;
    m = len_mask(c.len_log2);
    if (c.full)     return s + beat;
    else if (c.ilv) return (s & ~m) | ((s ^ beat) & m);
    else            return (s & ~m) | ((s + beat) & m);
  endfunction

endpackage

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg
  import bcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output burst_cfg_t        cfg,
  output logic [CL_W-1:0]   cas_lat
);

  logic [MODE_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word;
  end

  assign cfg     = decode_cfg(word_q);
  assign cas_lat = word_q[6:4];

  assert_full_not_ilv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.full |-> !cfg.ilv);

  assert_cas_follows_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cas_lat == $past(word[6:4]));

endmodule

// File: rtl/bcg_seq.sv
module bcg_seq
  import bcg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_ap,
  input  logic             stop,
  input  burst_cfg_t       cfg_in,
  output logic [COL_W-1:0] col,
  output logic             col_valid,
  output logic             col_last,
  output logic             ap_req
);

  logic             active_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] start_q;
  burst_cfg_t       cfg_q;
  logic             ap_q;
  logic             ap_req_q;

  // named internal events
  logic last_beat;
  logic burst_end;

  assign last_beat = active_q & ~cfg_q.full & (beat_q == len_mask(cfg_q.len_log2));
  assign burst_end = active_q & ~start & (stop | last_beat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      start_q  <= '0;
      cfg_q    <= '0;
      ap_q     <= 1'b0;
      ap_req_q <= 1'b0;
    end else begin
      ap_req_q <= burst_end & ap_q;
      if (start) begin
        active_q <= 1'b1;
        beat_q   <= '0;
        start_q  <= start_col;
        cfg_q    <= cfg_in;
        ap_q     <= start_ap;
      end else if (burst_end) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign col       = col_at(start_q, beat_q, cfg_q);
  assign col_valid = active_q;
  assign col_last  = last_beat;
  assign ap_req    = ap_req_q;

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col == $past(start_col)));

  assert_linear_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !cfg_q.full && !cfg_q.ilv) |->
      ((col & ~len_mask(cfg_q.len_log2)) == (start_q & ~len_mask(cfg_q.len_log2))));

  assert_full_no_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && cfg_q.full) |-> !col_last);

  assert_idle_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !start) |=> !col_valid);

  assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && stop && !start) |=> !col_valid);

  assert_ap_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ap_req |-> ($past(col_valid) && !col_valid));

  assert_ap_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ap_req |=> !ap_req);

  assert_last_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_load,
  input  logic [7:0]  mode_word,
  input  logic        start,
  input  logic [7:0]  start_col,
  input  logic        start_ap,
  input  logic        stop,
  output logic [2:0]  cas_lat,
  output logic [7:0]  col,
  output logic        col_valid,
  output logic        col_last,
  output logic        ap_req
);

  burst_cfg_t cfg_w;

  bcg_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (mode_load),
    .word    (mode_word),
    .cfg     (cfg_w),
    .cas_lat (cas_lat)
  );

  bcg_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .start_ap  (start_ap),
    .stop      (stop),
    .cfg_in    (cfg_w),
    .col       (col),
    .col_valid (col_valid),
    .col_last  (col_last),
    .ap_req    (ap_req)
  );

endmodule

// File: tb/test_burst_col_gen.sv
`timescale 1ns/1ps
module test_burst_col_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_load = 1'b0;
  logic [7:0] mode_word = '0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic       start_ap = 1'b0;
  logic       stop = 1'b0;
  logic [2:0] cas_lat;
  logic [7:0] col;
  logic       col_valid;
  logic       col_last;
  logic       ap_req;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  burst_col_gen i_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
    .start(start), .start_col(start_col), .start_ap(start_ap), .stop(stop),
    .cas_lat(cas_lat), .col(col), .col_valid(col_valid), .col_last(col_last),
    .ap_req(ap_req)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int beats_for(int code);
    if (code <= 3) return 1 << code;
    if (code == 7) return 0;
    return 1;
  endfunction

  function automatic int exp_col(int s, int b, int code, bit ilv);
    int n = beats_for(code);
    int base;
    if (n == 0) return (s + b) % 256;
    base = s - (s % n);
    if (ilv) return base + ((s ^ b) % n);
    return base + (((s % n) + b) % n);
  endfunction

  task automatic load_mode(logic [7:0] w);
    mode_load = 1'b1;
    mode_word = w;
    @(negedge clk);
    mode_load = 1'b0;
    chk("R1 cas_lat", cas_lat, w[6:4]);
  endtask

  // stop_at < 0: run to natural end (non-full only)
  task automatic burst(int code, bit ilv, int s, bit ap, int stop_at);
    int n = beats_for(code);
    int len;
    bit full = (n == 0);
    load_mode({1'b0, 3'($urandom_range(0, 7)), ilv, 3'(code)});
    start = 1'b1;
    start_col = 8'(s);
    start_ap = ap;
    @(negedge clk);
    start = 1'b0;
    len = n;
    if (stop_at >= 0 && (full || stop_at < n)) len = stop_at + 1;
    for (int b = 0; b < len; b++) begin
      chk(full ? "R5 valid" : "R6 valid", col_valid, 1);
      chk(full ? "R5 col" : (ilv ? "R4 col" : "R3 col"), col, exp_col(s, b, code, ilv));
      chk(full ? "R5 last" : "R6 last", col_last, (!full && b == n - 1) ? 1 : 0);
      if (b == len - 1 && b == stop_at) stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
    end
    chk(stop_at >= 0 ? "R7 end" : "R6 end", col_valid, 0);
    chk("R8 ap_req", ap_req, ap ? 1 : 0);
    @(negedge clk);
    chk("R8 ap_req pulse", ap_req, 0);
  endtask

  initial begin
    void'($urandom(32'h1a2b3c));
    repeat (3) @(negedge clk);
    chk("R11 valid", col_valid, 0);
    chk("R11 last", col_last, 0);
    chk("R11 ap_req", ap_req, 0);
    chk("R11 cas", cas_lat, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset mode is one beat, linear
    start = 1'b1; start_col = 8'd77; start_ap = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk("R2 first col", col, 77);
    chk("R11 one beat last", col_last, 1);
    @(negedge clk);
    chk("R11 one beat end", col_valid, 0);

    // R7: stop while idle has no effect
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R7 idle stop", col_valid, 0);

    // directed corners
    burst(3, 1'b0, 8'hFD, 1'b1, -1);  // R3 wrap within block of 8
    burst(3, 1'b1, 8'h25, 1'b0, -1);  // R4 interleaved
    burst(2, 1'b1, 8'h03, 1'b1, 1);   // R7 stop mid burst with R8 ap
    burst(5, 1'b1, 8'h10, 1'b1, -1);  // R1 reserved code -> 1 beat
    burst(7, 1'b1, 8'hF0, 1'b1, 299); // R5 full page wrap past 256, ilv ignored
    burst(7, 1'b0, 8'h00, 1'b0, 0);   // R5 stop at first beat

    // R9: restart during burst, start wins over stop
    load_mode(8'h03);
    start = 1'b1; start_col = 8'd5; start_ap = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 pre col", col, 5);
    @(negedge clk);
    chk("R9 pre col2", col, 6);
    start = 1'b1; stop = 1'b1; start_col = 8'd200; start_ap = 1'b0;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    chk("R9 restart col", col, 200);
    chk("R9 restart valid", col_valid, 1);
    chk("R9 no ap", ap_req, 0);
    // R10: change mode mid burst to 1 beat; burst stays 8 beats
    mode_load = 1'b1; mode_word = 8'h50;
    for (int b = 0; b < 8; b++) begin
      chk("R10 col", col, exp_col(200, b, 3, 1'b0));
      chk("R10 last", col_last, b == 7 ? 1 : 0);
      @(negedge clk);
      mode_load = 1'b0;
    end
    chk("R10 end", col_valid, 0);
    chk("R9 ap of new burst", ap_req, 0);
    chk("R1 cas after mid load", cas_lat, 5);

    // random bursts
    for (int i = 0; i < 60; i++) begin
      int r = $urandom_range(0, 5);
      int code = (r < 4) ? r : ((r == 4) ? 7 : 6);
      int n = beats_for(code);
      int sa;
      if (n == 0) sa = $urandom_range(0, 300);
      else sa = ($urandom_range(0, 1) == 1) ? -1 : $urandom_range(0, n - 1);
      burst(code, 1'($urandom_range(0, 1)), $urandom_range(0, 255),
            1'($urandom_range(0, 1)), sa);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule